// File: doc/BRIEF.md
# I2C Status Flag Register

This block keeps the eight-bit status byte of an I2C bus interface. The serial engine around it reports bus events as single-cycle pulses: a START or STOP condition seen on the wires, a byte finished after its acknowledge clock, an acknowledge or data bit sampled, arbitration lost, an address byte that matched or was a general call, and the R/W bit that came with the address. The block turns those pulses into flags. It also accepts two CPU strobes: a write to the status byte and a write to the data shift register.

The upper four bits are the mode and handshake flags, and the CPU can write them. These are the master bit, the direction bit, the bus-busy bit and the byte-pending flag. The lower four bits are event flags that only the engine can change: arbitration lost, address matched, general call and last received bit. The byte-pending flag drops when a byte finishes. When it drops, the block emits a one-clock interrupt pulse and asks the clock stage to hold SCL low until the CPU services the data register.

All flags are registered. When the events of one cycle conflict, a CPU write wins over everything else. Among the engine events, a clearing cause wins over a setting cause.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset the status byte reads 0x10: bit 4 (byte-pending, active low) is 1 and every other bit is 0. `irq` and `scl_hold` are 0.
- R2: A status write loads bits 7, 6 and 4 from the written byte, leaves bits 3..0 unchanged, and loads bit 5 only if bits 7 and 6 were both 1 before the write (master transmit). Otherwise bit 5 keeps its value.
- R3: A sampled bit (acknowledge or data) is stored in bit 0, with 0 meaning ACK. A data-register write clears bit 0, and this clear wins over a sample in the same cycle.
- R4: Bit 1 is set when a general call arrives while bit 7 is 0. A START or STOP clears it, and the clear wins over a simultaneous general call.
- R5: Bit 2 is set when an address match or a general call arrives while bit 7 is 0. A data-register write clears it.
- R6: Bit 4 goes to 0 when a byte completes. It goes to 1 on a data-register write, or while the enable input is 0. A CPU write in the same cycle as a byte completion wins.
- R7: `irq` is high for exactly the one clock in which bit 4 first reads 0 after having been 1. `scl_hold` is 1 whenever bit 4 is 0 and the block is enabled.
- R8: Bit 5 is set by START and cleared by STOP. If both arrive in one cycle it is cleared. It is held at 0 while the enable input is 0.
- R9: Arbitration loss while bits 7 and 6 are both 1 sets bit 3 and clears bit 6 at the same edge. Bit 7 stays 1 until the next byte completion, then clears.
- R10: In slave mode (bit 7 = 0) with the 7-bit addressing mode selected (`addr_10b` = 0), bit 6 takes the R/W bit delivered with a finished address byte. With 10-bit mode selected, the R/W bit is ignored.
- R11: Bit 6 is cleared by STOP, by arbitration loss, by START while bit 7 is 0, and by a NACK sample while bit 7 is 0.
- R12: A status write with bit 5 set, made in master transmit while bit 5 already reads 1, is a suppressed repeated START. Bit 6 reads 0 afterwards and bit 5 stays 1.
- R13: A data-register write clears bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable |
| addr_10b | input | 1 | Addressing mode: 0 selects 7-bit, 1 selects 10-bit |
| cpu_wr_stat | input | 1 | CPU write strobe for the status byte |
| cpu_wr_data | input | 1 | CPU write strobe for the data shift register |
| cpu_wdata | input | 8 | Byte written with `cpu_wr_stat` |
| ev_start | input | 1 | START condition detected |
| ev_stop | input | 1 | STOP condition detected |
| ev_byte_done | input | 1 | Last clock of a byte (including ACK) has fallen |
| ev_bit_vld | input | 1 | A bit was sampled on SDA |
| ev_bit_ack | input | 1 | The sampled bit was the acknowledge bit |
| ev_bit_val | input | 1 | Value of the sampled bit (1 = NACK in ACK position) |
| ev_arb_lost | input | 1 | Arbitration lost on SDA |
| ev_addr_done | input | 1 | An address byte has been received |
| ev_addr_hit | input | 1 | Received address matched the own address |
| ev_gen_call | input | 1 | All-zero general call address received |
| ev_rw | input | 1 | R/W bit of the received address |
| stat | output | 8 | Status byte |
| irq | output | 1 | One-clock interrupt pulse on byte completion |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
Every flag, and `irq` itself, is a register. A stimulus applied before a rising edge therefore shows up on `stat` and `irq` straight after that edge, one cycle later. `scl_hold` follows bit 4 in the same cycle and adds no extra delay. The bench drives inputs on the falling edge and samples every output on the next falling edge, so each check sits exactly one edge after its stimulus. A sweep writes all 256 status values in a chain, and the bench predicts each result from the previous predicted byte.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W = 8;
  // bit positions: software decodes them, so they are fixed
  localparam int B_LRB = 0;
  localparam int B_GC  = 1;
  localparam int B_AAS = 2;
  localparam int B_AL  = 3;
  localparam int B_PIN = 4;
  localparam int B_BB  = 5;
  localparam int B_TRX = 6;
  localparam int B_MST = 7;

  function automatic logic master_tx(input logic mst, input logic trx);
    return mst & trx;
  endfunction

  // START request written while the bus is already busy
  function automatic logic start_blocked(input logic wr, input logic wbb,
                                         input logic bb, input logic mst,
                                         input logic trx);
    return wr & wbb & bb & master_tx(mst, trx);
  endfunction

  function automatic logic [STAT_W-1:0] stat_pack(
      input logic mst, input logic trx, input logic bb, input logic pin,
      input logic al, input logic aas, input logic gc, input logic lrb);
    logic [STAT_W-1:0] s;
    s = '0;
    s[B_MST] = mst; s[B_TRX] = trx; s[B_BB] = bb; s[B_PIN] = pin;
    s[B_AL]  = al;  s[B_AAS] = aas; s[B_GC] = gc; s[B_LRB] = lrb;
    return s;
  endfunction
endpackage

// File: rtl/i2c_stat_pin.sv
module i2c_stat_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wr_data,
  input  logic wr_stat,
  input  logic wbit,
  input  logic byte_done,
  output logic pin,
  output logic irq,
  output logic scl_hold
);
  logic pin_nx;

  always_comb begin
    if (!en)           pin_nx = 1'b1;
    else if (wr_data)  pin_nx = 1'b1;
    else if (wr_stat)  pin_nx = wbit;
    else if (byte_done) pin_nx = 1'b0;
    else               pin_nx = pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= 1'b1;
      irq <= 1'b0;
    end else begin
      pin <= pin_nx;
      irq <= pin & ~pin_nx;
    end
  end

  assign scl_hold = en & ~pin;

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r7_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!pin && $past(pin)));
  a_r6_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pin);
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wr_data,
  input  logic wr_stat,
  input  logic wbb,
  input  logic mst,
  input  logic trx,
  input  logic start,
  input  logic stop,
  input  logic bit_vld,
  input  logic bit_val,
  input  logic arb_lost,
  input  logic addr_hit,
  input  logic gen_call,
  output logic lrb,
  output logic gc,
  output logic aas,
  output logic al,
  output logic bb
);
  import i2c_stat_pkg::*;

  logic mt;
  assign mt = master_tx(mst, trx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrb <= 1'b0; gc <= 1'b0; aas <= 1'b0; al <= 1'b0; bb <= 1'b0;
    end else begin
      // last received bit
      if (wr_data)      lrb <= 1'b0;
      else if (bit_vld) lrb <= bit_val;
      // general call: clears beat sets
      if (start || stop)        gc <= 1'b0;
      else if (gen_call && !mst) gc <= 1'b1;
      // address seen
      if (wr_data)                            aas <= 1'b0;
      else if ((addr_hit || gen_call) && !mst) aas <= 1'b1;
      // arbitration lost
      if (wr_data)              al <= 1'b0;
      else if (arb_lost && mt)  al <= 1'b1;
      // bus busy
      if (!en)                  bb <= 1'b0;
      else if (wr_stat && mt)   bb <= wbb;
      else if (stop)            bb <= 1'b0;
      else if (start)           bb <= 1'b1;
    end
  end

  a_r8_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bb);
  a_r4_gc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start || stop) |=> !gc);
  a_r3_lrb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !lrb);
  a_r9_al_set: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && mst && trx && !wr_data) |=> al);
endmodule

// File: rtl/i2c_stat_dir.sv
module i2c_stat_dir (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_10b,
  input  logic wr_stat,
  input  logic wmst,
  input  logic wtrx,
  input  logic wbb,
  input  logic bb,
  input  logic al,
  input  logic start,
  input  logic stop,
  input  logic byte_done,
  input  logic nack,
  input  logic arb_lost,
  input  logic addr_done,
  input  logic rw,
  output logic mst,
  output logic trx
);
  import i2c_stat_pkg::*;

  logic dup_start, trx_clr, trx_load, mst_drop;

  assign dup_start = start_blocked(wr_stat, wbb, bb, mst, trx);
  assign trx_clr   = arb_lost | stop | ((start | nack) & ~mst);
  assign trx_load  = addr_done & ~addr_10b & ~mst;
  assign mst_drop  = byte_done & (al | (arb_lost & master_tx(mst, trx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst <= 1'b0;
      trx <= 1'b0;
    end else begin
      if (wr_stat)       trx <= dup_start ? 1'b0 : wtrx;
      else if (trx_clr)  trx <= 1'b0;
      else if (trx_load) trx <= rw;

      if (wr_stat)       mst <= wmst;
      else if (mst_drop) mst <= 1'b0;
    end
  end

  a_r9_trx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !wr_stat) |=> !trx);
  a_r11_stop_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_stat) |=> !trx);
  a_r12_dup_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && mst && trx && bb && wbb) |=> !trx);
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              addr_10b,
  input  logic              cpu_wr_stat,
  input  logic              cpu_wr_data,
  input  logic [STAT_W-1:0] cpu_wdata,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_byte_done,
  input  logic              ev_bit_vld,
  input  logic              ev_bit_ack,
  input  logic              ev_bit_val,
  input  logic              ev_arb_lost,
  input  logic              ev_addr_done,
  input  logic              ev_addr_hit,
  input  logic              ev_gen_call,
  input  logic              ev_rw,
  output logic [STAT_W-1:0] stat,
  output logic              irq,
  output logic              scl_hold
);
  logic mst, trx, bb, pin, al, aas, gc, lrb;
  logic nack;
  logic unused_wlo;

  assign nack       = ev_bit_vld & ev_bit_ack & ev_bit_val;
  assign unused_wlo = ^cpu_wdata[B_AL:B_LRB];

  i2c_stat_pin u_pin (
    .clk(clk), .rst_n(rst_n), .en(en),
    .wr_data(cpu_wr_data), .wr_stat(cpu_wr_stat), .wbit(cpu_wdata[B_PIN]),
    .byte_done(ev_byte_done),
    .pin(pin), .irq(irq), .scl_hold(scl_hold)
  );

  i2c_stat_flags u_flags (
    .clk(clk), .rst_n(rst_n), .en(en),
    .wr_data(cpu_wr_data), .wr_stat(cpu_wr_stat), .wbb(cpu_wdata[B_BB]),
    .mst(mst), .trx(trx), .start(ev_start), .stop(ev_stop),
    .bit_vld(ev_bit_vld), .bit_val(ev_bit_val), .arb_lost(ev_arb_lost),
    .addr_hit(ev_addr_hit), .gen_call(ev_gen_call),
    .lrb(lrb), .gc(gc), .aas(aas), .al(al), .bb(bb)
  );

  i2c_stat_dir u_dir (
    .clk(clk), .rst_n(rst_n), .addr_10b(addr_10b),
    .wr_stat(cpu_wr_stat), .wmst(cpu_wdata[B_MST]), .wtrx(cpu_wdata[B_TRX]),
    .wbb(cpu_wdata[B_BB]), .bb(bb), .al(al),
    .start(ev_start), .stop(ev_stop), .byte_done(ev_byte_done), .nack(nack),
    .arb_lost(ev_arb_lost), .addr_done(ev_addr_done), .rw(ev_rw),
    .mst(mst), .trx(trx)
  );

  assign stat = stat_pack(mst, trx, bb, pin, al, aas, gc, lrb);

  a_r2_low_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_stat && !cpu_wr_data && !ev_bit_vld && !ev_start && !ev_stop &&
     !ev_gen_call && !ev_addr_hit && !ev_arb_lost)
    |=> (stat[B_AL:B_LRB] == $past(stat[B_AL:B_LRB])));
endmodule

// File: tb/sim_i2c_stat_reg.sv
module sim_i2c_stat_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, addr_10b = 1'b0;
  logic cpu_wr_stat = 1'b0, cpu_wr_data = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic ev_start = 0, ev_stop = 0, ev_byte_done = 0, ev_bit_vld = 0;
  logic ev_bit_ack = 0, ev_bit_val = 0, ev_arb_lost = 0, ev_addr_done = 0;
  logic ev_addr_hit = 0, ev_gen_call = 0, ev_rw = 0;
  logic [7:0] stat;
  logic irq, scl_hold;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_stat_reg u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .addr_10b(addr_10b),
    .cpu_wr_stat(cpu_wr_stat), .cpu_wr_data(cpu_wr_data), .cpu_wdata(cpu_wdata),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte_done(ev_byte_done),
    .ev_bit_vld(ev_bit_vld), .ev_bit_ack(ev_bit_ack), .ev_bit_val(ev_bit_val),
    .ev_arb_lost(ev_arb_lost), .ev_addr_done(ev_addr_done),
    .ev_addr_hit(ev_addr_hit), .ev_gen_call(ev_gen_call), .ev_rw(ev_rw),
    .stat(stat), .irq(irq), .scl_hold(scl_hold)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_ev();
    cpu_wr_stat = 0; cpu_wr_data = 0; ev_start = 0; ev_stop = 0;
    ev_byte_done = 0; ev_bit_vld = 0; ev_bit_ack = 0; ev_bit_val = 0;
    ev_arb_lost = 0; ev_addr_done = 0; ev_addr_hit = 0; ev_gen_call = 0;
    ev_rw = 0;
  endtask

  // one rising edge, then back to the falling edge to sample
  task automatic tick();
    @(negedge clk);
    clr_ev();
  endtask

  task automatic do_reset();
    clr_ev(); en = 1; addr_10b = 0;
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] e, v;
    logic mt, bbn, trxn;
    do_reset();
    // R1 reset state
    chk("R1 stat", stat, 8'h10);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 hold", {7'd0, scl_hold}, 8'h00);

    // R2/R6/R7/R12 chained sweep over every status write value
    e = 8'h10;
    for (int i = 0; i < 256; i++) begin
      v = i[7:0];
      mt = e[7] & e[6];
      bbn = mt ? v[5] : e[5];
      trxn = (mt & v[5] & e[5]) ? 1'b0 : v[6];
      cpu_wdata = v; cpu_wr_stat = 1; tick();
      chk("R2 R12 sweep stat", stat, {v[7], trxn, bbn, v[4], e[3:0]});
      chk("R7 sweep irq", {7'd0, irq}, {7'd0, e[4] & ~v[4]});
      chk("R7 sweep hold", {7'd0, scl_hold}, {7'd0, ~v[4]});
      e = {v[7], trxn, bbn, v[4], e[3:0]};
    end

    do_reset();
    // R3 last bit
    ev_bit_vld = 1; ev_bit_val = 1; tick();
    chk("R3 sample", {7'd0, stat[0]}, 8'h01);
    cpu_wr_data = 1; tick();
    chk("R3 data wr clears", {7'd0, stat[0]}, 8'h00);
    ev_bit_vld = 1; ev_bit_val = 1; tick();
    ev_bit_vld = 1; ev_bit_val = 1; cpu_wr_data = 1; tick();
    chk("R3 write wins", {7'd0, stat[0]}, 8'h00);

    // R4/R5 general call and address flag
    ev_gen_call = 1; tick();
    chk("R4 gc set", {6'd0, stat[2:1]}, 8'h03);
    ev_start = 1; tick();
    chk("R4 start clears gc, R5 keeps", {6'd0, stat[2:1]}, 8'h02);
    ev_gen_call = 1; ev_stop = 1; tick();
    chk("R4 clear wins", {7'd0, stat[1]}, 8'h00);
    cpu_wr_data = 1; tick();
    chk("R5 data wr clears", {7'd0, stat[2]}, 8'h00);
    ev_addr_hit = 1; tick();
    chk("R5 addr hit", {7'd0, stat[2]}, 8'h01);

    // R6/R7 byte completion
    ev_byte_done = 1; tick();
    chk("R6 pin low", {7'd0, stat[4]}, 8'h00);
    chk("R7 irq pulse", {7'd0, irq}, 8'h01);
    chk("R7 hold", {7'd0, scl_hold}, 8'h01);
    tick();
    chk("R7 irq one cycle", {7'd0, irq}, 8'h00);
    chk("R6 pin stays low", {7'd0, stat[4]}, 8'h00);
    cpu_wr_data = 1; tick();
    chk("R6 data wr sets", {7'd0, stat[4]}, 8'h01);
    chk("R7 hold released", {7'd0, scl_hold}, 8'h00);
    ev_byte_done = 1; cpu_wr_data = 1; tick();
    chk("R6 write wins", {7'd0, stat[4]}, 8'h01);
    chk("R7 no irq", {7'd0, irq}, 8'h00);
    ev_byte_done = 1; tick();
    en = 0; tick();
    chk("R6 disable sets", {7'd0, stat[4]}, 8'h01);
    chk("R7 hold off disabled", {7'd0, scl_hold}, 8'h00);
    en = 1; tick();

    // R8 bus busy
    ev_start = 1; tick();
    chk("R8 start", {7'd0, stat[5]}, 8'h01);
    ev_stop = 1; tick();
    chk("R8 stop", {7'd0, stat[5]}, 8'h00);
    ev_start = 1; ev_stop = 1; tick();
    chk("R8 both", {7'd0, stat[5]}, 8'h00);
    ev_start = 1; tick();
    en = 0; tick();
    chk("R8 disabled", {7'd0, stat[5]}, 8'h00);
    en = 1; tick();

    // R10 direction from R/W
    ev_addr_done = 1; ev_rw = 1; tick();
    chk("R10 rw=1", {7'd0, stat[6]}, 8'h01);
    ev_addr_done = 1; ev_rw = 0; tick();
    chk("R10 rw=0", {7'd0, stat[6]}, 8'h00);
    ev_addr_done = 1; ev_rw = 1; tick();
    addr_10b = 1; ev_addr_done = 1; ev_rw = 0; tick();
    chk("R10 10-bit ignores rw", {7'd0, stat[6]}, 8'h01);
    addr_10b = 0;

    // R11 direction clears
    ev_start = 1; tick();
    chk("R11 start slave", {7'd0, stat[6]}, 8'h00);
    ev_addr_done = 1; ev_rw = 1; tick();
    ev_bit_vld = 1; ev_bit_ack = 1; ev_bit_val = 1; tick();
    chk("R11 nack", {7'd0, stat[6]}, 8'h00);
    ev_addr_done = 1; ev_rw = 1; tick();
    ev_stop = 1; tick();
    chk("R11 stop", {7'd0, stat[6]}, 8'h00);

    // R9/R13 arbitration loss in master transmit
    cpu_wdata = 8'hD0; cpu_wr_stat = 1; tick();
    chk("R9 master tx", stat[7:6], 8'h03);
    ev_arb_lost = 1; tick();
    chk("R9 al set", {7'd0, stat[3]}, 8'h01);
    chk("R9 trx cleared", {7'd0, stat[6]}, 8'h00);
    chk("R9 mst kept", {7'd0, stat[7]}, 8'h01);
    ev_byte_done = 1; tick();
    chk("R9 mst dropped", {7'd0, stat[7]}, 8'h00);
    chk("R9 irq", {7'd0, irq}, 8'h01);
    cpu_wr_data = 1; tick();
    chk("R13 al cleared", {7'd0, stat[3]}, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule